// File: doc/BRIEF.md
# Nonvolatile SRAM Store/Recall Controller

This block is the control core of a byte-wide nonvolatile static RAM. Each clock cycle in which chip enable is low is one access: a read when write enable is high, a write when write enable is low. A second, shadow array holds the nonvolatile copy of the data. A STORE copies the working array into the shadow array, and a RECALL copies it back. While either transfer runs, the `busy` output is high and every access is refused.

A STORE starts in one of two ways. Software can start it by reading six fixed addresses in an exact order, which keeps the part usable on a plain SRAM bus. The controller also starts one by itself when the synchronized supply-good input falls, but only if the memory holds unsaved writes. A RECALL runs when supply-good first rises after reset, and again each time it rises after a low-power period.

The arrays are modelled as internal registers. They hold `2**ARR_W` bytes and are indexed by the low `ARR_W` bits of the 15-bit address. The transfer lengths are the parameters `T_STORE` and `T_RECALL`, counted in clock cycles.

Top module: `nvsram_ctrl`

## Requirements
- R1: A cycle with `ce_n`=0, `we_n`=1 and `oe_n`=0 while `busy` is low reads a byte. In the next cycle `dout` holds the byte at `addr[ARR_W-1:0]` and `dout_en` is 1. After a read with `oe_n`=1, `dout_en` is 0.
- R2: A cycle with `ce_n`=0 and `we_n`=0 while `busy` is low writes `din` to `addr[ARR_W-1:0]`. In the next cycle `dout_en` is 0, even when `oe_n` is low.
- R3: Reads of hex 0E38, 31C7, 03E0, 3C1F, 303F, 0FC0 in this order, with no other access between them, start a STORE. `busy` is high in the cycle after the sixth read. The level of `oe_n` on these reads does not matter, and the STORE runs whether or not any write has happened.
- R4: Any read outside the expected step, or any write, aborts a partly entered unlock sequence. An aborting read of 0E38 counts as a new first step. Idle cycles between steps do not abort the sequence.
- R5: A STORE holds `busy` high for exactly `T_STORE` cycles. When it ends, the shadow array equals the working array.
- R6: While `busy` is high, writes change nothing, reads return nothing, and `dout_en` stays 0.
- R7: When the synchronized `pwr_ok` falls, a STORE starts three cycles later, but only if a write has happened since the last STORE or RECALL ended. Otherwise `busy` stays low.
- R8: A RECALL copies the shadow array into the working array and holds `busy` high for exactly `T_RECALL` cycles. It starts when `pwr_ok` is first seen high after reset, and when `pwr_ok` rises again after a fall.
- R9: The end of any STORE or RECALL clears the unsaved-write flag, and every accepted write sets it.
- R10: During and directly after reset, `busy` and `dout_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 15 | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data |
| dout_en | output | 1 | Read data drive enable |
| pwr_ok | input | 1 | Supply above switch threshold (asynchronous) |
| busy | output | 1 | STORE or RECALL in progress |

## Verification
The bench tries to break the unlock detector in four ways. It inserts a foreign read in the middle of a sequence, inserts a write in the middle of one, restarts a sequence with a repeated first key, and sends sequence reads with output enable high. A detector that fails to abort on a foreign read or a write would start a STORE that should never happen. A detector that does not let 0E38 restart the sequence would miss a STORE that should happen.

The bench drops power on a clean memory and expects `busy` to stay low. A design that ignores the unsaved-write flag would start a STORE there. The bench also drops power on a dirty memory and expects a STORE, so a design that never sets the flag would fail that case.

Writes made while power is low are followed by a RECALL, and the bench expects the stored value back. A missing or reversed copy shows up as wrong read data. Writes and reads issued during a transfer must leave no trace afterwards.

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl #(
  parameter int ARR_W    = 8,
  parameter int T_STORE  = 16,
  parameter int T_RECALL = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ce_n,
  input  logic        oe_n,
  input  logic        we_n,
  input  logic [14:0] addr,
  input  logic [7:0]  din,
  output logic [7:0]  dout,
  output logic        dout_en,
  input  logic        pwr_ok,
  output logic        busy
);
  localparam int DEPTH = 1 << ARR_W;
  localparam int TMAX  = (T_STORE > T_RECALL) ? T_STORE : T_RECALL;
  localparam int CW    = $clog2(TMAX + 1);

  function automatic logic [14:0] key(input logic [2:0] i);
    case (i)
      3'd0:    key = 15'h0E38;
      3'd1:    key = 15'h31C7;
      3'd2:    key = 15'h03E0;
      3'd3:    key = 15'h3C1F;
      3'd4:    key = 15'h303F;
      default: key = 15'h0FC0;
    endcase
  endfunction

  logic [7:0]       sram   [DEPTH];
  logic [7:0]       shadow [DEPTH];
  logic             s1, s2, s3;
  logic             recall_req, dirty, is_recall, rd_q;
  logic [CW-1:0]    cnt;
  logic [2:0]       step;
  logic [ARR_W-1:0] idx;
  logic             rd, wr, seq_hit, last, pfall, go_store, go_recall, done;

  assign idx       = addr[ARR_W-1:0];
  assign rd        = !ce_n && we_n && !busy;
  assign wr        = !ce_n && !we_n && !busy;
  assign seq_hit   = rd && (addr == key(step));
  assign last      = seq_hit && (step == 3'd5);
  assign pfall     = s3 && !s2;
  assign go_store  = !busy && (last || (pfall && dirty));
  assign go_recall = !busy && !go_store && s2 && recall_req;
  assign done      = busy && (cnt == '0);
  assign dout_en   = rd_q && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {s1, s2, s3} <= '0;
      recall_req   <= 1'b1;
      dirty        <= 1'b0;
      busy         <= 1'b0;
      is_recall    <= 1'b0;
      cnt          <= '0;
      step         <= '0;
      rd_q         <= 1'b0;
    end else begin
      s1   <= pwr_ok;
      s2   <= s1;
      s3   <= s2;
      rd_q <= rd && !oe_n;
      if (pfall) recall_req <= 1'b1;
      if (busy || last)                   step <= '0;
      else if (seq_hit)                   step <= step + 3'd1;
      else if (rd && addr == key(3'd0))   step <= 3'd1;
      else if (rd || wr)                  step <= '0;
      if (wr) dirty <= 1'b1;
      if (go_store) begin
        busy      <= 1'b1;
        is_recall <= 1'b0;
        cnt       <= CW'(T_STORE - 1);
        step      <= '0;
      end else if (go_recall) begin
        busy       <= 1'b1;
        is_recall  <= 1'b1;
        cnt        <= CW'(T_RECALL - 1);
        recall_req <= 1'b0;
      end else if (done) begin
        busy  <= 1'b0;
        dirty <= 1'b0;
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr) sram[idx] <= din;
    if (rd) dout <= sram[idx];
    if (done) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (is_recall) sram[i]   <= shadow[i];
        else           shadow[i] <= sram[i];
      end
    end
  end
endmodule

// File: rtl/nvsram_ctrl_chk.sv
module nvsram_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic oe_n,
  input logic we_n,
  input logic busy,
  input logic dout_en,
  input logic dirty
);
  p_busy_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !dout_en);
  p_write_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !we_n) |=> !dout_en);
  p_read_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && we_n && !oe_n && !busy) |=> (dout_en || busy));
  p_busy_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy);
  p_write_dirty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !we_n && !busy) |=> dirty);
  p_done_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !dirty);
endmodule

bind nvsram_ctrl nvsram_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .busy(busy), .dout_en(dout_en), .dirty(dirty)
);

// File: tb/tb_nvsram_ctrl.sv
module tb_nvsram_ctrl;
  localparam int CLK_P = 10;
  localparam int ARR_W = 8, T_STORE = 16, T_RECALL = 12;
  localparam int DEPTH = 1 << ARR_W;
  localparam logic [14:0] KEYS [6] = '{15'h0E38, 15'h31C7, 15'h03E0,
                                       15'h3C1F, 15'h303F, 15'h0FC0};

  logic clk = 0, rst_n = 0, ce_n = 1, oe_n = 1, we_n = 1, pwr_ok = 1;
  logic [14:0] addr = '0;
  logic [7:0]  din = '0, dout;
  logic        dout_en, busy;

  int checks = 0, fails = 0;
  logic [7:0] m_sram [DEPTH];
  logic [7:0] m_shad [DEPTH];
  bit v_sram [DEPTH];
  bit v_shad [DEPTH];

  nvsram_ctrl #(.ARR_W(ARR_W), .T_STORE(T_STORE), .T_RECALL(T_RECALL)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
    .pwr_ok(pwr_ok), .busy(busy));

  always #(CLK_P/2) clk = ~clk;

  function automatic int ix(input logic [14:0] a);
    return int'(a[ARR_W-1:0]);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic acc(input logic [14:0] a, input logic w, input logic oe, input logic [7:0] d);
    @(negedge clk);
    ce_n = 0; we_n = !w; oe_n = !oe; addr = a; din = d;
    @(negedge clk);
    ce_n = 1; we_n = 1; oe_n = 1;
  endtask

  task automatic wr_m(input logic [14:0] a, input logic [7:0] d);
    acc(a, 1, 1, d);
    m_sram[ix(a)] = d; v_sram[ix(a)] = 1;
  endtask

  task automatic rd_chk(input logic [14:0] a, input string tag);
    acc(a, 0, 1, 8'h00);
    check(dout_en === 1'b1, {tag, " dout_en"}, dout_en, 1);
    if (v_sram[ix(a)]) check(dout === m_sram[ix(a)], {tag, " data"}, dout, m_sram[ix(a)]);
  endtask

  task automatic do_store();
    for (int i = 0; i < DEPTH; i++) begin m_shad[i] = m_sram[i]; v_shad[i] = v_sram[i]; end
  endtask

  task automatic do_recall();
    for (int i = 0; i < DEPTH; i++) begin m_sram[i] = m_shad[i]; v_sram[i] = v_shad[i]; end
  endtask

  task automatic xfer_len(input int exp, input string tag);
    int n = 0;
    int w = 0;
    while (!busy && w < 8) begin @(negedge clk); w++; end
    check(busy === 1'b1, {tag, " start"}, busy, 1);
    while (busy && n < 200) begin n++; @(negedge clk); end
    check(n == exp, {tag, " length"}, n, exp);
  endtask

  task automatic quiet(input int n, input string tag);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (busy) seen = 1; end
    check(!seen, tag, seen, 0);
  endtask

  task automatic keys(input int from, input int to, input bit oe);
    for (int k = from; k <= to; k++) acc(KEYS[k], 0, oe, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [14:0] a;
    void'($urandom(32'd7321));
    for (int i = 0; i < DEPTH; i++) begin v_sram[i] = 0; v_shad[i] = 0; m_sram[i] = 0; m_shad[i] = 0; end
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && dout_en === 1'b0, "R10 in reset", {busy, dout_en}, 0);
    rst_n = 1;
    check(busy === 1'b0 && dout_en === 1'b0, "R10 after reset", {busy, dout_en}, 0);
    xfer_len(T_RECALL, "R8 power-up recall");
    do_recall();

    wr_m(15'h0011, 8'hA5);
    rd_chk(15'h0011, "R1 read back");
    acc(15'h0011, 0, 0, 8'h00);
    check(dout_en === 1'b0, "R1 oe high no drive", dout_en, 0);
    @(negedge clk); ce_n = 0; we_n = 0; oe_n = 0; addr = 15'h0022; din = 8'h3C;
    @(negedge clk); ce_n = 1; we_n = 1; oe_n = 1;
    m_sram[ix(15'h0022)] = 8'h3C; v_sram[ix(15'h0022)] = 1;
    check(dout_en === 1'b0, "R2 write with oe low", dout_en, 0);
    rd_chk(15'h0022, "R2 written data");

    for (int i = 0; i < 300; i++) begin
      a = 15'($urandom);
      if ($urandom % 2) wr_m(a, 8'($urandom));
      else if ($urandom % 4 == 0) begin
        acc(a, 0, 0, 8'h00);
        check(dout_en === 1'b0, "R1 random oe high", dout_en, 0);
      end else rd_chk(a, "R1 random read");
    end

    keys(0, 5, 0);
    check(busy === 1'b1, "R3 sw store oe high", busy, 1);
    xfer_len(T_STORE, "R5 sw store");
    do_store();

    keys(0, 5, 1);
    xfer_len(T_STORE, "R3 sw store clean");
    do_store();

    keys(0, 2, 1); acc(15'h0100, 0, 1, 8'h00); keys(3, 5, 1);
    quiet(6, "R4 foreign read aborts");
    keys(0, 2, 1); wr_m(15'h0044, 8'h77); keys(3, 5, 1);
    quiet(6, "R4 write aborts");
    keys(0, 1, 1); keys(0, 5, 1);
    check(busy === 1'b1, "R4 first key restarts", busy, 1);
    acc(15'h0044, 1, 0, 8'hEE);
    check(dout_en === 1'b0, "R6 no drive while busy", dout_en, 0);
    acc(15'h0044, 0, 1, 8'h00);
    check(dout_en === 1'b0, "R6 read while busy", dout_en, 0);
    while (busy) @(negedge clk);
    do_store();
    rd_chk(15'h0044, "R6 write ignored");

    wr_m(15'h0055, 8'h12);
    keys(0, 5, 1);
    xfer_len(T_STORE, "R5 store before power");
    do_store();
    pwr_ok = 0;
    quiet(8, "R7 clean power drop skips store");
    wr_m(15'h0055, 8'h99);
    pwr_ok = 1;
    xfer_len(T_RECALL, "R8 recall on power return");
    do_recall();
    rd_chk(15'h0055, "R8 recalled data");
    pwr_ok = 0;
    quiet(8, "R9 recall clears dirty");
    pwr_ok = 1;
    xfer_len(T_RECALL, "R8 second recall");
    do_recall();

    wr_m(15'h0055, 8'h5A);
    pwr_ok = 0;
    xfer_len(T_STORE, "R7 dirty power drop stores");
    do_store();
    wr_m(15'h0055, 8'h01);
    pwr_ok = 1;
    xfer_len(T_RECALL, "R8 recall after auto store");
    do_recall();
    rd_chk(15'h0055, "R5 auto stored data");

    summary();
  end
endmodule